// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value for precision time synchronization. The reference clock driving it has a period that is not a whole number of nanoseconds. Each reference tick arrives as a one-cycle `ref_tick` pulse in the block's clock domain. On every tick the block adds a fixed-point period to the count. That period has a 10-bit integer part and a 32-bit fraction. A 32-bit accumulator collects the fraction, and its carry-out adds one extra nanosecond.

Software reaches the block through a word-addressed 32-bit register port. Through it, software loads the counter, trims the rate by changing the period, and applies phase steps through a separate 64-bit offset. The time reported on `time_now` and through the register port is the counter plus the offset.

Every 64-bit value is accessed as two 32-bit words, low word first. A small two-state write sequencer sits in front of the counter and another in front of the offset. Its states are SEQ_EMPTY and SEQ_LOW_HELD. A low-word write moves the sequencer from SEQ_EMPTY to SEQ_LOW_HELD, and a further low-word write in SEQ_LOW_HELD replaces the held word. A high-word write in SEQ_LOW_HELD loads the 64-bit value and returns the sequencer to SEQ_EMPTY. A high-word write in SEQ_EMPTY is dropped.

Reads work the other way. Reading a low word captures the matching high word, so a later high-word read returns a consistent 64-bit value.

Top module: `tod_counter`

## Requirements
- R1: After reset, the control word reads 0x00030000 (source 0, disabled, integer period 3), the fraction register reads 12 (about 333.33 MHz), and the counter, offset, accumulator and `time_now` are all zero.
- R2: While the enable bit is 0, ticks leave the counter and the accumulator unchanged, and every register stays readable. When the block is enabled again, it resumes from the held accumulator value.
- R3: On each tick while enabled, the accumulator adds the fraction modulo 2^32. The counter adds the integer period plus that addition's carry-out.
- R4: The integer period is written to control bits 25:16 (address 0). It takes effect only when the fraction register (address 1) is written, and then both values change in the same cycle. Until then, ticks use the old pair, and reading the control word shows the pending integer.
- R5: A write to address 2 holds a low word without touching the counter. A following write to address 3 loads the counter with {high, held low}.
- R6: A write to address 3 is ignored if no write to address 2 has occurred since reset or since the last load.
- R7: A read of address 2 returns counter bits 31:0 and captures bits 63:32. A later read of address 3 returns the captured word, even if the counter has moved since.
- R8: `time_now` equals the counter plus the offset, modulo 2^64. Addresses 6 and 7 read this sum, low word first, with the high word captured on the low read.
- R9: The offset is written through addresses 4 (low, held) and 5 (high, loads) with the same sequencing as the counter. It reads back directly at addresses 4 and 5. A two's-complement value steps the reported time backwards, and loading the offset leaves the counter unchanged.
- R10: Control bit 2 is the enable. Bits 1:0 pick the reference source, shown on `clk_sel`, and only codes 0, 1 and 2 are valid. A write that carries code 3 leaves the source unchanged but still updates the enable and the pending period.
- R11: Read data appears on `host_rdata` with `host_rvalid` high in the cycle after the `host_rd` strobe. `host_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Word address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| clk_sel | output | 2 | Selected reference source code |
| tmr_en | output | 1 | Timer enable |
| time_now | output | 64 | Counter plus offset in nanoseconds |

## Verification
The counter is driven with three kinds of fraction:
- The reset fraction of 12 gives a pure integer step over a short run, which isolates the integer path.
- A fraction of one half gives a carry on every second tick.
- A fraction of one third gives an irregular carry pattern, which exposes a wrong carry width or a wrong accumulator width.

The period-change sequence runs ticks between the control write and the fraction write, which separates deferred commit from immediate use. Counter loads place the value just below a 32-bit boundary, and ticks then occur between a low read and the following high read. That pattern tells a latched high word from a live one.

A negative offset that moves the reported time across the same boundary checks the modulo-2^64 sum and its own read latch.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SRC_W    = 2;
    localparam int EN_BIT   = 2;
    localparam int INT_LSB  = 16;
    localparam logic [SRC_W-1:0] SRC_RSVD = 2'd3;

    typedef enum logic [3:0] {
        A_CTRL   = 4'd0,
        A_FRAC   = 4'd1,
        A_CNT_LO = 4'd2,
        A_CNT_HI = 4'd3,
        A_OFF_LO = 4'd4,
        A_OFF_HI = 4'd5,
        A_NOW_LO = 4'd6,
        A_NOW_HI = 4'd7
    } reg_addr_e;

    typedef enum logic {
        SEQ_EMPTY    = 1'b0,
        SEQ_LOW_HELD = 1'b1
    } seq_state_e;
endpackage

// File: rtl/tod_stage64.sv
module tod_stage64 #(
    parameter int DW = 32,
    localparam int VW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic          load,
    output logic [VW-1:0] value
);
    import tod_pkg::*;

    seq_state_e    state_q, state_d;
    logic [DW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)        low_q <= '0;
        else if (wr_lo) low_q <= wdata;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_EMPTY: begin
                if (wr_lo) state_d = SEQ_LOW_HELD;
            end
            SEQ_LOW_HELD: begin
                if (wr_hi) begin
                    load    = 1'b1;
                    state_d = SEQ_EMPTY;
                end
            end
        endcase
    end

    assign value = {wdata, low_q};
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int CW = 64,
    parameter int FW = 32,
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic [IW-1:0] inc_int,
    input  logic [FW-1:0] inc_frac,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt
);
    logic [FW-1:0] acc_q;
    logic [FW:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, inc_frac};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            acc_q <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en && tick) begin
            acc_q <= sum[FW-1:0];
            cnt   <= cnt + CW'(inc_int) + CW'(sum[FW]);
        end
    end
endmodule

// File: rtl/tod_regs.sv
module tod_regs #(
    parameter int DW         = 32,
    parameter int IW         = 10,
    parameter int RESET_INT  = 3,
    parameter int RESET_FRAC = 12,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [3:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] off,
    input  logic [CW-1:0] now,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic [1:0]    clk_sel,
    output logic          en,
    output logic [IW-1:0] int_act,
    output logic [DW-1:0] frac_act,
    output logic [1:0]    wr_lo_v,
    output logic [1:0]    wr_hi_v
);
    import tod_pkg::*;

    logic [IW-1:0] int_pend;
    logic [DW-1:0] ctrl_word;
    logic [DW-1:0] cnt_hi_lat, now_hi_lat;

    assign wr_lo_v = {host_wr && host_addr == A_OFF_LO, host_wr && host_addr == A_CNT_LO};
    assign wr_hi_v = {host_wr && host_addr == A_OFF_HI, host_wr && host_addr == A_CNT_HI};

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sel  <= '0;
            en       <= 1'b0;
            int_pend <= IW'(RESET_INT);
            int_act  <= IW'(RESET_INT);
            frac_act <= DW'(RESET_FRAC);
        end else if (host_wr) begin
            if (host_addr == A_CTRL) begin
                en       <= host_wdata[EN_BIT];
                int_pend <= host_wdata[INT_LSB +: IW];
                if (host_wdata[SRC_W-1:0] != SRC_RSVD) clk_sel <= host_wdata[SRC_W-1:0];
            end else if (host_addr == A_FRAC) begin
                frac_act <= host_wdata;
                int_act  <= int_pend;
            end
        end
    end

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[SRC_W-1:0]     = clk_sel;
        ctrl_word[EN_BIT]        = en;
        ctrl_word[INT_LSB +: IW] = int_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
            cnt_hi_lat  <= '0;
            now_hi_lat  <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                case (host_addr)
                    A_CTRL:   host_rdata <= ctrl_word;
                    A_FRAC:   host_rdata <= frac_act;
                    A_CNT_LO: begin
                        host_rdata <= cnt[DW-1:0];
                        cnt_hi_lat <= cnt[CW-1:DW];
                    end
                    A_CNT_HI: host_rdata <= cnt_hi_lat;
                    A_OFF_LO: host_rdata <= off[DW-1:0];
                    A_OFF_HI: host_rdata <= off[CW-1:DW];
                    A_NOW_LO: begin
                        host_rdata <= now[DW-1:0];
                        now_hi_lat <= now[CW-1:DW];
                    end
                    A_NOW_HI: host_rdata <= now_hi_lat;
                    default:  host_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int DATA_W     = 32,
    parameter int INT_W      = 10,
    parameter int RESET_INT  = 3,
    parameter int RESET_FRAC = 12,
    localparam int CW = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [1:0]        clk_sel,
    output logic              tmr_en,
    output logic [CW-1:0]     time_now
);
    logic [INT_W-1:0]  int_act;
    logic [DATA_W-1:0] frac_act;
    logic [1:0]        wr_lo_v, wr_hi_v, ld_v;
    logic [CW-1:0]     val_v [2];
    logic [CW-1:0]     cnt, off_q;

    tod_regs #(
        .DW(DATA_W), .IW(INT_W), .RESET_INT(RESET_INT), .RESET_FRAC(RESET_FRAC)
    ) u_regs (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .cnt(cnt), .off(off_q), .now(time_now),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .clk_sel(clk_sel), .en(tmr_en), .int_act(int_act), .frac_act(frac_act),
        .wr_lo_v(wr_lo_v), .wr_hi_v(wr_hi_v)
    );

    // channel 0 stages the counter, channel 1 the offset
    for (genvar g = 0; g < 2; g++) begin : g_stage
        tod_stage64 #(.DW(DATA_W)) u_stage (
            .clk(clk), .rst(rst), .wr_lo(wr_lo_v[g]), .wr_hi(wr_hi_v[g]),
            .wdata(host_wdata), .load(ld_v[g]), .value(val_v[g])
        );
    end

    tod_accum #(.CW(CW), .FW(DATA_W), .IW(INT_W)) u_accum (
        .clk(clk), .rst(rst), .tick(ref_tick), .en(tmr_en),
        .inc_int(int_act), .inc_frac(frac_act),
        .load(ld_v[0]), .load_val(val_v[0]), .cnt(cnt)
    );

    always_ff @(posedge clk) begin
        if (rst)        off_q <= '0;
        else if (ld_v[1]) off_q <= val_v[1];
    end

    assign time_now = cnt + off_q;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
    parameter int CW = 64,
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          ref_tick,
    input logic          tmr_en,
    input logic          host_wr,
    input logic          host_rd,
    input logic [3:0]    host_addr,
    input logic          host_rvalid,
    input logic [1:0]    clk_sel,
    input logic [IW-1:0] int_act,
    input logic          cnt_load,
    input logic [CW-1:0] cnt_load_val,
    input logic [CW-1:0] cnt
);
    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !cnt_load) |=> cnt == $past(cnt));

    assert_tick_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && ref_tick && !cnt_load) |=>
            (cnt == $past(cnt) + CW'($past(int_act))) ||
            (cnt == $past(cnt) + CW'($past(int_act)) + CW'(1)));

    assert_period_deferred_R4: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_addr == 4'd1) |=> $stable(int_act));

    assert_load_value_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> cnt == $past(cnt_load_val));

    assert_src_valid_R10: assert property (@(posedge clk) disable iff (rst)
        clk_sel != 2'd3);

    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid);
endmodule

bind tod_counter tod_counter_chk #(.CW(CW), .IW(INT_W)) u_chk (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .tmr_en(tmr_en),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_rvalid(host_rvalid), .clk_sel(clk_sel), .int_act(int_act),
    .cnt_load(ld_v[0]), .cnt_load_val(val_v[0]), .cnt(cnt)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [1:0]  clk_sel;
    logic        tmr_en;
    logic [63:0] time_now;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // bench model of the block
    logic [63:0] m_cnt = '0, m_off = '0;
    logic [31:0] m_acc = '0, m_frac = 32'd12;
    logic [9:0]  m_int = 10'd3;
    logic        m_en = 1'b0;

    always #2 clk = ~clk;

    tod_counter u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .clk_sel(clk_sel), .tmr_en(tmr_en), .time_now(time_now)
    );

    task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check64(64'd1, 64'd0, "R11 unexpected rvalid");
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check64({32'd0, host_rdata}, {32'd0, e}, t);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        ref_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_en) begin
                automatic logic [32:0] s = {1'b0, m_acc} + {1'b0, m_frac};
                m_acc = s[31:0];
                m_cnt = m_cnt + 64'(m_int) + 64'(s[32]);
            end
        end
        ref_tick = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [9:0] pend;
        logic [63:0] nowv;
        pend = 10'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, 32'h0003_0000, "R1 ctrl reset");
        rd(4'd1, 32'd12, "R1 fraction reset");
        rd(4'd2, 32'd0, "R1 counter low reset");
        rd(4'd3, 32'd0, "R1 counter high reset");
        rd(4'd4, 32'd0, "R1 offset reset");
        @(negedge clk);
        check64(time_now, 64'd0, "R1 time_now reset");

        // R2 disabled ticks change nothing
        tick(5);
        rd(4'd2, 32'd0, "R2 counter held while disabled");

        // R4 pending integer period, not yet used
        wr(4'd0, (32'd6 << 16) | 32'd4); m_en = 1'b1; pend = 10'd6;
        rd(4'd0, 32'h0006_0004, "R4 ctrl shows pending integer");
        tick(3);
        rd(4'd2, m_cnt[31:0], "R4 old period used before fraction write");
        wr(4'd1, 32'h8000_0000); m_int = pend; m_frac = 32'h8000_0000;
        tick(4);
        rd(4'd2, m_cnt[31:0], "R3 half fraction carries every second tick");
        wr(4'd1, 32'h5555_5555); m_frac = 32'h5555_5555;
        tick(7);
        rd(4'd2, m_cnt[31:0], "R3 third fraction carry pattern");

        // R2 disable holds accumulator, registers readable
        wr(4'd0, (32'd6 << 16)); m_en = 1'b0;
        tick(4);
        rd(4'd2, m_cnt[31:0], "R2 counter held after disable");
        rd(4'd1, 32'h5555_5555, "R2 fraction readable while disabled");
        wr(4'd0, (32'd6 << 16) | 32'd4); m_en = 1'b1;
        tick(2);
        rd(4'd2, m_cnt[31:0], "R2 resume from held accumulator");

        // R6 high word without low ignored
        wr(4'd3, 32'h77);
        rd(4'd2, m_cnt[31:0], "R6 lone high write ignored low");
        rd(4'd3, m_cnt[63:32], "R6 lone high write ignored high");

        // R5 staged load
        wr(4'd2, 32'hFFFF_FFF0);
        rd(4'd2, m_cnt[31:0], "R5 low write alone leaves counter");
        wr(4'd3, 32'h1); m_cnt = 64'h1_FFFF_FFF0;
        rd(4'd2, 32'hFFFF_FFF0, "R5 loaded low word");
        rd(4'd3, 32'h1, "R5 loaded high word");
        wr(4'd3, 32'h5);
        rd(4'd2, 32'hFFFF_FFF0, "R6 second high write ignored");
        rd(4'd3, 32'h1, "R6 second high write ignored high");

        // R7 latched high across a 32-bit carry
        wr(4'd0, (32'd8 << 16) | 32'd4); pend = 10'd8;
        wr(4'd1, 32'h0); m_int = pend; m_frac = 32'h0;
        rd(4'd2, m_cnt[31:0], "R7 low read before carry");
        tick(3);
        rd(4'd3, 32'h1, "R7 high word latched on low read");
        rd(4'd2, m_cnt[31:0], "R3 low after boundary");
        rd(4'd3, m_cnt[63:32], "R3 high after boundary");

        // R9 / R8 offset
        wr(4'd4, 32'hFFFF_FFF0);
        @(negedge clk);
        check64(time_now, m_cnt, "R9 offset low write alone no effect");
        wr(4'd5, 32'hFFFF_FFFF); m_off = 64'hFFFF_FFFF_FFFF_FFF0;
        rd(4'd4, 32'hFFFF_FFF0, "R9 offset low readback");
        rd(4'd5, 32'hFFFF_FFFF, "R9 offset high readback");
        rd(4'd2, m_cnt[31:0], "R9 counter untouched by offset");
        @(negedge clk);
        check64(time_now, m_cnt + m_off, "R8 time_now with negative offset");
        nowv = m_cnt + m_off;
        rd(4'd6, nowv[31:0], "R8 current time low");
        tick(2);
        rd(4'd7, nowv[63:32], "R8 current time high latched");
        nowv = m_cnt + m_off;
        rd(4'd6, nowv[31:0], "R8 current time low after ticks");
        rd(4'd7, nowv[63:32], "R8 current time high after ticks");

        // R10 source select
        @(negedge clk);
        check64({62'd0, clk_sel}, 64'd0, "R10 source code 0");
        wr(4'd0, (32'd8 << 16) | 32'd6);
        @(negedge clk);
        check64({62'd0, clk_sel}, 64'd2, "R10 source code 2");
        wr(4'd0, (32'd8 << 16) | 32'd7);
        @(negedge clk);
        check64({62'd0, clk_sel}, 64'd2, "R10 code 3 ignored");
        check64({63'd0, tmr_en}, 64'd1, "R10 enable bit");
        rd(4'd0, 32'h0008_0006, "R10 ctrl readback");

        // R11 rvalid idle
        @(negedge clk);
        check64({63'd0, host_rvalid}, 64'd0, "R11 rvalid low when idle");
        check64(64'(exp_q.size()), 64'd0, "R11 all reads answered");
        finish_run();
    end
endmodule